// File: doc/BRIEF.md
# Power-Mode and Clock-Source Controller

This controller decides which of seven power states a small processor core is in and which of three clock sources drives it. The sources are primary, secondary and internal. Software writes an 8-bit control word that holds a low-power choice bit and a two-bit source request. A one-cycle strobe from the core's sleep instruction then moves the core into a low-power state: Idle if the choice bit is set, Sleep if it is clear.

In the Run and Idle states the controller follows the source request. It moves to the new source as soon as that source says it is ready. Until then it stays on the old source and raises a pending flag. A wake event takes the core from Idle or Sleep back to Run on the requested source, waiting for that source if needed. The outputs are the selected source, an enable for the CPU clock, an enable for the peripheral clock, and a three-bit mode code. Oscillators, glitch-free clock multiplexing and startup timing are modelled only through the ready flags and the enable outputs.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is 1 (Run on primary). Both clock enables are 1, the source select is 3'b001, the pending flag is 0, the choice bit is 0 and the source request is 00.
- R2: A write stores bit 7 as the choice bit and bits 1:0 as the source request. The request decodes as 00 = primary, 01 = secondary, 10 or 11 = internal. Bits 6:2 have no effect.
- R3: The mode code is 0 for Sleep. Run is 1, 2 or 3 for primary, secondary or internal. Idle is 5, 6 or 7 for the same three sources. The source select is one-hot, with bit 0 primary, bit 1 secondary and bit 2 internal.
- R4: In Run or Idle, if the requested source differs from the current one and its ready flag (src_rdy bit 0 primary, 1 secondary, 2 internal) is 1, the select moves to it on the next clock edge.
- R5: While the requested source is not ready, the current source is kept and the pending flag is 1. The switch happens on the first edge at which the ready flag is 1.
- R6: A sleep strobe in Run with the choice bit at 1 gives Idle on the current source. In Idle the CPU enable is 0 and the peripheral enable is 1.
- R7: A sleep strobe in Run with the choice bit at 0 gives Sleep. In Sleep both enables are 0, the select is 3'b000 and the pending flag is 0.
- R8: When the stored choice bit and source request already match the target, a sleep strobe with no write is enough to enter the low-power state. The choice bit used is the one stored before any write in the same cycle.
- R9: A wake event in Idle or Sleep returns the core to Run on the requested source at the next edge if that source is ready. If it is not ready, the return is remembered and happens on the first edge at which it is ready.
- R10: A sleep strobe in Idle or Sleep is ignored.
- R11: A wake event in Run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word: bit 7 choice bit, bits 1:0 source request |
| sleep_req | input | 1 | One-cycle sleep instruction strobe |
| wake_evt | input | 1 | Wake event |
| src_rdy | input | 3 | Ready flags: bit 0 primary, 1 secondary, 2 internal |
| src_sel | output | 3 | One-hot active source, all zero in Sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode | output | 3 | Current mode code |
| switch_pend | output | 1 | Requested source is not yet the active one |

## Verification
The hardest cases to reach combine a stalled source with a state change. One is a wake from Sleep while the requested source is not ready, where the remembered wake must survive several cycles before completing. Another is a source switch still pending when the sleep strobe arrives. Directed sequences hold a ready flag low across a wake or a strobe and release it later. A long stretch of random writes, strobes, wakes and ready patterns follows, compared every cycle with a behavioural model.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int CFG_W    = 8,
  parameter int IDLE_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             sleep_req,
  input  logic             wake_evt,
  input  logic [2:0]       src_rdy,
  output logic [2:0]       src_sel,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic [2:0]       mode,
  output logic             switch_pend
);
  typedef enum logic [1:0] {K_RUN, K_IDLE, K_SLEEP} kind_t;

  kind_t      kind;
  logic       idle_en, wake_hold;
  logic [1:0] src_fld, cur, tgt;
  logic       tgt_rdy, wake_go;

  assign tgt     = (src_fld == 2'b00) ? 2'd1 : (src_fld == 2'b01) ? 2'd2 : 2'd3;
  assign tgt_rdy = src_rdy[tgt - 2'd1];
  assign wake_go = (kind != K_RUN) && (wake_evt || wake_hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind      <= K_RUN;
      cur       <= 2'd1;
      idle_en   <= 1'b0;
      src_fld   <= 2'b00;
      wake_hold <= 1'b0;
    end else begin
      if (cfg_we) begin
        idle_en <= cfg_wdata[IDLE_BIT];
        src_fld <= cfg_wdata[1:0];
      end
      if (kind != K_SLEEP && tgt != cur && tgt_rdy)
        cur <= tgt;
      if (kind == K_RUN) begin
        if (sleep_req) kind <= idle_en ? K_IDLE : K_SLEEP;
      end else if (wake_go) begin
        if (tgt_rdy) begin
          kind      <= K_RUN;
          cur       <= tgt;
          wake_hold <= 1'b0;
        end else begin
          wake_hold <= 1'b1;
        end
      end
    end
  end

  assign cpu_clk_en  = (kind == K_RUN);
  assign per_clk_en  = (kind != K_SLEEP);
  assign src_sel     = (kind == K_SLEEP) ? 3'b000 : (3'b001 << (cur - 2'd1));
  assign mode        = (kind == K_SLEEP) ? 3'd0 : {kind == K_IDLE, cur};
  assign switch_pend = (kind != K_SLEEP) && (tgt != cur);

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_sel));
  p_idle_gating_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode[2] |-> (!cpu_clk_en && per_clk_en && src_sel != 3'b000));
  p_sleep_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> (!cpu_clk_en && !per_clk_en && src_sel == 3'b000 && !switch_pend));
  p_hold_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && switch_pend && !tgt_rdy && !sleep_req) |=> $stable(src_sel));
  p_sleep_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SLEEP && !wake_evt && !wake_hold) |=> (kind == K_SLEEP));
  p_wake_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && wake_evt && tgt_rdy) |=> cpu_clk_en);
  p_run_wake_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !sleep_req) |=> cpu_clk_en);
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       sleep_req = 1'b0;
  logic       wake_evt = 1'b0;
  logic [2:0] src_rdy = 3'b111;
  logic [2:0] src_sel, mode;
  logic       cpu_clk_en, per_clk_en, switch_pend;

  int checks = 0, fails = 0;

  // reference state: kind 0 run, 1 idle, 2 sleep; source index 0..2
  int m_kind, m_cur, m_ie, m_fld, m_wh;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .src_rdy(src_rdy), .src_sel(src_sel),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .mode(mode), .switch_pend(switch_pend));

  function automatic int want_idx(int fld);
    if (fld == 0) return 0;
    if (fld == 1) return 1;
    return 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_kind = 0; m_cur = 0; m_ie = 0; m_fld = 0; m_wh = 0;
    end else begin
      int t, nk, nc, nwh;
      t = want_idx(m_fld);
      nk = m_kind; nc = m_cur; nwh = m_wh;
      if (m_kind != 2 && t != m_cur && src_rdy[t]) nc = t;
      if (m_kind == 0) begin
        if (sleep_req) nk = m_ie ? 1 : 2;
      end else if (wake_evt || m_wh != 0) begin
        if (src_rdy[t]) begin nk = 0; nc = t; nwh = 0; end
        else nwh = 1;
      end
      if (cfg_we) begin m_ie = cfg_wdata[7]; m_fld = cfg_wdata[1:0]; end
      m_kind = nk; m_cur = nc; m_wh = nwh;
    end
  end

  task automatic compare(string tag);
    logic [2:0] e_mode, e_sel;
    logic e_cpu, e_per, e_pend;
    e_mode = (m_kind == 2) ? 3'd0 : 3'(m_cur + 1 + (m_kind == 1 ? 4 : 0));
    e_sel  = (m_kind == 2) ? 3'b000 : 3'(1 << m_cur);
    e_cpu  = (m_kind == 0);
    e_per  = (m_kind != 2);
    e_pend = (m_kind != 2) && (want_idx(m_fld) != m_cur);
    checks++;
    if (mode !== e_mode || src_sel !== e_sel || cpu_clk_en !== e_cpu ||
        per_clk_en !== e_per || switch_pend !== e_pend) begin
      fails++;
      $display("FAIL %s t=%0t: mode/sel/cpu/per/pend got %0d/%b/%b/%b/%b expected %0d/%b/%b/%b/%b",
        tag, $time, mode, src_sel, cpu_clk_en, per_clk_en, switch_pend,
        e_mode, e_sel, e_cpu, e_per, e_pend);
    end
  endtask

  task automatic cyc(bit we, logic [7:0] wd, bit slp, bit wk, logic [2:0] rdy, string tag);
    cfg_we = we; cfg_wdata = wd; sleep_req = slp; wake_evt = wk; src_rdy = rdy;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle_n(int n, logic [2:0] rdy, string tag);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, rdy, tag);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); compare("R1");
    @(negedge clk); rst_n = 1'b1;
    idle_n(2, 3'b111, "R1");
    // R2 / R4: decode and immediate switch
    cyc(1, 8'h01, 0, 0, 3'b111, "R4"); idle_n(1, 3'b111, "R2");
    cyc(1, 8'h02, 0, 0, 3'b111, "R2"); idle_n(1, 3'b111, "R2");
    cyc(1, 8'h03, 0, 0, 3'b111, "R2"); idle_n(1, 3'b111, "R2");
    cyc(1, 8'h7C, 0, 0, 3'b111, "R2"); idle_n(1, 3'b111, "R3");
    // R11: wake in run
    cyc(0, 8'h00, 0, 1, 3'b111, "R11"); idle_n(1, 3'b111, "R11");
    // R5: secondary not ready
    cyc(1, 8'h01, 0, 0, 3'b101, "R5"); idle_n(4, 3'b101, "R5");
    idle_n(2, 3'b111, "R5");
    // R6 / R10: idle then repeated strobe
    cyc(1, 8'h80, 0, 0, 3'b111, "R6"); idle_n(1, 3'b111, "R4");
    cyc(0, 8'h00, 1, 0, 3'b111, "R6"); idle_n(2, 3'b111, "R6");
    cyc(0, 8'h00, 1, 0, 3'b111, "R10"); idle_n(2, 3'b111, "R10");
    // R9: wake from idle
    cyc(0, 8'h00, 0, 1, 3'b111, "R9"); idle_n(1, 3'b111, "R9");
    // R8: strobe alone
    cyc(0, 8'h00, 1, 0, 3'b111, "R8"); idle_n(1, 3'b111, "R8");
    cyc(0, 8'h00, 0, 1, 3'b111, "R9");
    // R7: sleep, strobe ignored, wake with source stalled
    cyc(1, 8'h00, 0, 0, 3'b111, "R7");
    cyc(1, 8'h80, 1, 0, 3'b111, "R8"); idle_n(2, 3'b111, "R7");
    cyc(0, 8'h00, 1, 0, 3'b111, "R10"); idle_n(2, 3'b111, "R10");
    cyc(0, 8'h00, 0, 1, 3'b110, "R9"); idle_n(5, 3'b110, "R9");
    idle_n(2, 3'b111, "R9");
    // pending switch across idle entry
    cyc(1, 8'h82, 0, 0, 3'b011, "R5");
    cyc(0, 8'h00, 1, 0, 3'b011, "R5"); idle_n(3, 3'b011, "R5");
    idle_n(1, 3'b111, "R4");
    cyc(0, 8'h00, 0, 1, 3'b111, "R9"); idle_n(1, 3'b111, "R3");
    // random stretch
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cyc(r < 15, 8'($urandom), r >= 15 && r < 25, r >= 25 && r < 40,
          (r % 3 == 0) ? 3'($urandom) : 3'b111, "R3");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule